// File: doc/BRIEF.md
# Receive Descriptor Lookahead DMA Manager

This block sits between a receive byte FIFO and a descriptor ring in system memory. Software prepares a ring of receive descriptors. Each descriptor holds an ownership flag, a buffer pointer and a buffer length. The block polls the descriptor at the current ring position until the controller owns it. It then caches that descriptor and waits for a frame. Incoming bytes collect in a holding queue. They are not copied to memory until a threshold number of bytes has arrived, or until the frame ends before the threshold. This keeps short runt frames out of host buffers.

When the threshold byte arrives, the block reads the following ring entry early and caches it. If that early read shows the host still owns the entry, the block does not treat it as an error. It keeps filling the buffer it already holds. When that buffer fills and the frame continues, it reads the entry once more as a last chance. If the host still owns it, the block writes an error status, returns the buffer and discards the rest of the frame.

Each finished buffer is handed back with its ownership flag cleared. The first buffer of a frame carries a start marker and the last carries an end marker with the whole frame length. An interrupt flag is raised at frame end or on an error. It can optionally be raised as soon as the first buffer of a frame is handed back, so that software can start on the header while later buffers are still being filled.

Top module: `rxdesc_lookahead_dma`

## Requirements
- R1: While the current ring entry has its own bit clear, the block re-reads it and writes no frame data; once the host sets own, queued frame bytes go into that entry's buffer.
- R2: For a frame of THRESH (64) bytes or more, no byte is written to a buffer before THRESH bytes of that frame have been accepted.
- R3: On reaching THRESH bytes, the block reads the next ring entry; if that entry is owned, the block moves into it at buffer-full without a further read.
- R4: If the early read finds the next entry host-owned, the block keeps filling its current buffer with no error. A last-chance re-read at buffer-full that finds the entry owned lets the frame continue there.
- R5: If the last-chance re-read still shows host ownership, the current entry is written back with buff=1 and enp=0. The remaining bytes of the frame are discarded, and the next frame starts at the entry after it.
- R6: A write-back word is {own[27], stp[26], enp[25], buff[24], len[23:12], ptr[11:0]}. It always has own=0 and stp=1 only for the frame's first buffer. Non-final buffers return len equal to their buffer length and the original ptr.
- R7: The final buffer of a frame is written back with enp=1 and len equal to the total frame byte count.
- R8: A frame shorter than THRESH bytes is written wholly into the first buffer when its end marker has been received. No next-entry read is made before the data movement.
- R9: The irq output rises one cycle after a write-back with enp=1 or buff=1. It stays high until irq_clr is pulsed.
- R10: With early_irq_en high, a write-back with stp=1 also raises irq. With it low, a non-final stp write-back leaves irq unchanged.
- R11: The ring position advances by one per write-back and wraps from RING_LEN-1 to 0.
- R12: Frame byte k of a buffer is written to address ptr+k, in frame order, with the byte value received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block takes the byte this cycle when rx_valid is high |
| desc_rd | output | 1 | Descriptor read strobe; data returns next cycle |
| desc_wr | output | 1 | Descriptor write-back strobe |
| desc_idx | output | IDX_W | Ring entry addressed by the read or write |
| desc_rd_own | input | 1 | Own bit of the entry read last cycle |
| desc_rd_len | input | 12 | Buffer length of the entry read last cycle |
| desc_rd_ptr | input | 12 | Buffer pointer of the entry read last cycle |
| desc_wdata | output | 28 | Write-back word |
| buf_wr | output | 1 | Frame byte write strobe |
| buf_addr | output | 12 | Frame byte address |
| buf_data | output | 8 | Frame byte |
| early_irq_en | input | 1 | Enables the interrupt on the first-buffer write-back |
| irq_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| irq | output | 1 | Receive interrupt flag |

## Verification
Descriptor read data is due on the cycle after desc_rd. Frame bytes appear on buf_wr one cycle after they leave the holding queue. A write-back is visible on desc_wr during its own state. irq follows one cycle after that write-back. The bench samples every output on the falling clock edge. Its monitor compares each buf_wr and desc_wr against queued expectations as soon as it appears. The monitor checks irq at the falling edge after the write-back that should set it, so each result is compared in the cycle it is due and not later. The threshold rule is checked against the number of bytes already handed to the block when the first write of a long frame appears. Ignored or held-off cases are checked by counting buffer writes over a waiting window.

// File: rtl/rxla_pkg.sv
// Shared widths, descriptor layout and controller states for the receive
// descriptor lookahead manager. Assumes 12-bit buffer addresses and lengths.
package rxla_pkg;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 12;

    typedef struct packed {
        logic              own;
        logic              stp;
        logic              enp;
        logic              buff;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] ptr;
    } rxla_desc_t;

    localparam int DESC_W = $bits(rxla_desc_t);

    typedef enum logic [3:0] {
        ST_POLL_RD,
        ST_POLL_CHK,
        ST_WAIT,
        ST_LA_RD,
        ST_LA_CHK,
        ST_XFER,
        ST_LC_RD,
        ST_LC_CHK,
        ST_WB,
        ST_DROP
    } rxla_state_e;
endpackage

// File: rtl/rxla_byte_fifo.sv
// Holding queue for received bytes tagged with an end marker.
// Assumes DEPTH is a power of two of at least 2; pushes only when not full.
module rxla_byte_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign dout    = mem_q[rd_q];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_pop_has_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rxla_ring_ptr.sv
// Ring position counter: holds the current entry and offers the following one.
// Assumes RING_LEN is a power of two from 1 to 128.
module rxla_ring_ptr #(
    parameter int RING_LEN = 4,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_LEN - 1);

    generate
        if (RING_LEN == 1) begin : g_single
            assign cur_idx = '0;
            assign nxt_idx = '0;
        end else begin : g_ring
            logic [IDX_W-1:0] cur_q;

            // Following entry with wrap at the ring end.
            always_comb nxt_idx = (cur_q == LAST) ? '0 : cur_q + 1'b1;

            // Advance once per write-back.
            always_ff @(posedge clk) begin
                if (!rst_n)   cur_q <= '0;
                else if (adv) cur_q <= nxt_idx;
            end

            assign cur_idx = cur_q;

            assert_ring_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (adv && cur_idx == LAST) |=> (cur_idx == '0));
        end
    endgenerate
endmodule

// File: rtl/rxla_irq_flag.sv
// Sticky receive interrupt flag; a set wins over a simultaneous clear.
module rxla_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    // Set on a qualifying write-back, clear on a host write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq <= 1'b0;
        else if (set) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
endmodule

// File: rtl/rxdesc_lookahead_dma.sv
// Receive descriptor manager: polls the ring, holds frame data back until a
// threshold, looks ahead to the next entry early and again at buffer-full,
// moves bytes into buffers and hands entries back with status.
// Assumes one frame in flight: input stalls after an end marker until that
// frame is fully handled. Descriptor reads return data one cycle later.
module rxdesc_lookahead_dma
    import rxla_pkg::*;
#(
    parameter int RING_LEN = 4,
    parameter int THRESH   = 64,
    localparam int IDX_W   = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              desc_rd,
    output logic              desc_wr,
    output logic [IDX_W-1:0]  desc_idx,
    input  logic              desc_rd_own,
    input  logic [LEN_W-1:0]  desc_rd_len,
    input  logic [ADDR_W-1:0] desc_rd_ptr,
    output logic [DESC_W-1:0] desc_wdata,
    output logic              buf_wr,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    input  logic              early_irq_en,
    input  logic              irq_clr,
    output logic              irq
);
    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] THR = CNT_W'(THRESH);

    rxla_state_e       state_q;
    logic [CNT_W-1:0]  in_cnt_q;
    logic              closed_q;
    logic [ADDR_W-1:0] cur_ptr_q, nxt_ptr_q;
    logic [LEN_W-1:0]  cur_len_q, nxt_len_q;
    logic              nxt_own_q, first_q, wb_enp_q, wb_err_q;
    logic [LEN_W-1:0]  offs_q, tot_q, offs_inc;
    logic              accept, fifo_empty, fifo_full, fifo_pop, frame_done, irq_set;
    logic [8:0]        fifo_dout;
    logic [IDX_W-1:0]  cur_idx, nxt_idx;
    rxla_desc_t        wb;

    assign rx_ready   = !fifo_full && !closed_q;
    assign accept     = rx_valid && rx_ready;
    assign fifo_pop   = (state_q == ST_XFER || state_q == ST_DROP) && !fifo_empty;
    assign offs_inc   = offs_q + 1'b1;
    assign frame_done = (state_q == ST_WB && wb_enp_q) ||
                        (state_q == ST_DROP && !fifo_empty && fifo_dout[8]);

    rxla_byte_fifo #(.WIDTH(9), .DEPTH(THRESH)) u_hold (
        .clk(clk), .rst_n(rst_n), .push(accept), .pop(fifo_pop),
        .din({rx_eof, rx_data}), .dout(fifo_dout),
        .empty(fifo_empty), .full(fifo_full)
    );

    rxla_ring_ptr #(.RING_LEN(RING_LEN), .IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .adv(desc_wr),
        .cur_idx(cur_idx), .nxt_idx(nxt_idx)
    );

    rxla_irq_flag u_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .irq(irq)
    );

    // Count accepted bytes of the frame (saturating) and note its end marker.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_done) begin
            in_cnt_q <= '0;
            closed_q <= 1'b0;
        end else if (accept) begin
            if (rx_sof)             in_cnt_q <= CNT_W'(1);
            else if (in_cnt_q < THR) in_cnt_q <= in_cnt_q + 1'b1;
            if (rx_eof)             closed_q <= 1'b1;
        end
    end

    // Descriptor and data movement controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_POLL_RD;
            cur_ptr_q <= '0;
            cur_len_q <= '0;
            nxt_ptr_q <= '0;
            nxt_len_q <= '0;
            nxt_own_q <= 1'b0;
            first_q   <= 1'b0;
            wb_enp_q  <= 1'b0;
            wb_err_q  <= 1'b0;
            offs_q    <= '0;
            tot_q     <= '0;
            buf_wr    <= 1'b0;
            buf_addr  <= '0;
            buf_data  <= '0;
        end else begin
            buf_wr <= 1'b0;
            case (state_q)
                ST_POLL_RD:  state_q <= ST_POLL_CHK;
                ST_POLL_CHK: begin
                    if (desc_rd_own) begin
                        cur_ptr_q <= desc_rd_ptr;
                        cur_len_q <= desc_rd_len;
                        state_q   <= ST_WAIT;
                    end else begin
                        state_q <= ST_POLL_RD;
                    end
                end
                ST_WAIT: begin
                    offs_q  <= '0;
                    tot_q   <= '0;
                    first_q <= 1'b1;
                    if (in_cnt_q >= THR) begin
                        state_q <= ST_LA_RD;
                    end else if (closed_q) begin
                        nxt_own_q <= 1'b0;
                        state_q   <= ST_XFER;
                    end
                end
                ST_LA_RD:  state_q <= ST_LA_CHK;
                ST_LA_CHK: begin
                    nxt_own_q <= desc_rd_own;
                    nxt_ptr_q <= desc_rd_ptr;
                    nxt_len_q <= desc_rd_len;
                    state_q   <= ST_XFER;
                end
                ST_XFER: begin
                    if (!fifo_empty) begin
                        buf_wr   <= 1'b1;
                        buf_addr <= cur_ptr_q + offs_q;
                        buf_data <= fifo_dout[7:0];
                        offs_q   <= offs_inc;
                        tot_q    <= tot_q + 1'b1;
                        if (fifo_dout[8]) begin
                            wb_enp_q <= 1'b1;
                            wb_err_q <= 1'b0;
                            state_q  <= ST_WB;
                        end else if (offs_inc == cur_len_q) begin
                            wb_enp_q <= 1'b0;
                            wb_err_q <= 1'b0;
                            state_q  <= nxt_own_q ? ST_WB : ST_LC_RD;
                        end
                    end
                end
                ST_LC_RD:  state_q <= ST_LC_CHK;
                ST_LC_CHK: begin
                    nxt_own_q <= desc_rd_own;
                    nxt_ptr_q <= desc_rd_ptr;
                    nxt_len_q <= desc_rd_len;
                    wb_err_q  <= !desc_rd_own;
                    state_q   <= ST_WB;
                end
                ST_WB: begin
                    if (wb_enp_q) begin
                        state_q <= ST_POLL_RD;
                    end else if (wb_err_q) begin
                        state_q <= ST_DROP;
                    end else begin
                        cur_ptr_q <= nxt_ptr_q;
                        cur_len_q <= nxt_len_q;
                        nxt_own_q <= 1'b0;
                        first_q   <= 1'b0;
                        offs_q    <= '0;
                        state_q   <= ST_XFER;
                    end
                end
                ST_DROP: begin
                    if (!fifo_empty && fifo_dout[8]) state_q <= ST_POLL_RD;
                end
                default: state_q <= ST_POLL_RD;
            endcase
        end
    end

    // Memory port strobes, address selection and write-back word.
    always_comb begin
        desc_rd  = (state_q == ST_POLL_RD) || (state_q == ST_LA_RD) || (state_q == ST_LC_RD);
        desc_wr  = (state_q == ST_WB);
        desc_idx = (state_q == ST_LA_RD || state_q == ST_LC_RD) ? nxt_idx : cur_idx;
        wb.own   = 1'b0;
        wb.stp   = first_q;
        wb.enp   = wb_enp_q;
        wb.buff  = wb_err_q;
        wb.len   = wb_enp_q ? tot_q : cur_len_q;
        wb.ptr   = cur_ptr_q;
        irq_set  = desc_wr && (wb_enp_q || wb_err_q || (first_q && early_irq_en));
    end

    assign desc_wdata = wb;

    assert_hold_until_thresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && !fifo_empty) |-> (in_cnt_q >= THR || closed_q));
    assert_wb_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> !desc_wdata[DESC_W-1]);
    assert_err_stops_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_wdata[DESC_W-4]) |=> !buf_wr);
    assert_enp_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_wdata[DESC_W-3]) |=> irq);
endmodule

// File: tb/rxdesc_lookahead_dma_bench.sv
// Scoreboard bench: tasks queue expected writes; a monitor compares them.
module rxdesc_lookahead_dma_bench;
    import rxla_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int RING       = 4;
    localparam int IDXW       = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_ready, desc_rd, desc_wr, buf_wr, irq;
    logic [IDXW-1:0] desc_idx;
    logic [DESC_W-1:0] desc_wdata;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0] buf_data;
    logic early_irq_en = 1'b0, irq_clr = 1'b0;

    logic [DESC_W-1:0] dmem [RING];
    logic [DESC_W-1:0] rdq = '0;
    logic host_we = 1'b0;
    logic [IDXW-1:0] host_idx = '0;
    logic [DESC_W-1:0] host_word = '0;

    int n_tests = 0, n_fail = 0, fed_cnt = 0, wr_count = 0;
    bit thresh_chk = 0, irq_chk = 0, irq_exp = 0;
    int q_da[$], q_dd[$], q_wi[$];
    logic [DESC_W-1:0] q_ww[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxdesc_lookahead_dma #(.RING_LEN(RING), .THRESH(64)) u_rxdesc_lookahead_dma (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .rx_ready(rx_ready),
        .desc_rd(desc_rd), .desc_wr(desc_wr), .desc_idx(desc_idx),
        .desc_rd_own(rdq[DESC_W-1]), .desc_rd_len(rdq[23:12]), .desc_rd_ptr(rdq[11:0]),
        .desc_wdata(desc_wdata), .buf_wr(buf_wr), .buf_addr(buf_addr),
        .buf_data(buf_data), .early_irq_en(early_irq_en), .irq_clr(irq_clr), .irq(irq)
    );

    // Descriptor memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (desc_rd) rdq <= dmem[desc_idx];
        if (desc_wr) dmem[desc_idx] <= desc_wdata;
        if (host_we) dmem[host_idx] <= host_word;
    end

    function automatic logic [DESC_W-1:0] mk(input bit o, input bit s, input bit e,
                                             input bit b, input int len, input int ptr);
        return {o, s, e, b, LEN_W'(len), ADDR_W'(ptr)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Monitor: compares every result on the falling edge where it is due.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_chk) begin
                chk("R9/R10 irq after write-back", int'(irq), int'(irq_exp));
                irq_chk = 0;
            end
            if (buf_wr) begin
                wr_count++;
                if (thresh_chk) begin
                    chk("R2 bytes received before first write", int'(fed_cnt >= 64), 1);
                    thresh_chk = 0;
                end
                if (q_da.size() == 0) begin
                    chk("R12 unexpected buffer write", int'({buf_addr, buf_data}), -1);
                end else begin
                    chk("R12 buffer write", int'({buf_addr, buf_data}),
                        (q_da.pop_front() << 8) | q_dd.pop_front());
                end
            end
            if (desc_wr) begin
                if (q_wi.size() == 0) begin
                    chk("R6 unexpected write-back", int'(desc_wdata), -1);
                end else begin
                    chk("R11 write-back index", int'(desc_idx), q_wi.pop_front());
                    chk("R6/R7 write-back word", int'(desc_wdata), int'(q_ww.pop_front()));
                end
                irq_exp = irq | desc_wdata[25] | desc_wdata[24] | (desc_wdata[26] & early_irq_en);
                irq_chk = 1;
            end
        end
    end

    task automatic host_write(input int idx, input logic [DESC_W-1:0] w);
        @(negedge clk);
        host_we = 1; host_idx = IDXW'(idx); host_word = w;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit s, input bit e);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1; rx_data = d; rx_sof = s; rx_eof = e;
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        fed_cnt++;
    endtask

    task automatic send_frame(input int n, input int seed, input int grant_at,
                              input int gidx, input logic [DESC_W-1:0] gw);
        fed_cnt = 0;
        thresh_chk = (n >= 64);
        for (int i = 0; i < n; i++) begin
            if (i == grant_at) host_write(gidx, gw);
            send_byte(8'(seed + i), i == 0, i == n - 1);
        end
    endtask

    task automatic exp_bytes(input int ptr, input int first, input int cnt, input int seed);
        for (int k = 0; k < cnt; k++) begin
            q_da.push_back(ptr + k);
            q_dd.push_back((seed + first + k) & 8'hFF);
        end
    endtask

    task automatic exp_wb(input int idx, input logic [DESC_W-1:0] w);
        q_wi.push_back(idx);
        q_ww.push_back(w);
    endtask

    task automatic drain();
        int t = 0;
        while ((q_da.size() != 0 || q_wi.size() != 0) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk("R12 all expected writes seen", q_da.size() + q_wi.size(), 0);
        repeat (10) @(negedge clk);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
        @(negedge clk);
        chk("R9 irq cleared by irq_clr", int'(irq), 0);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < RING; i++) host_write(i, '0);
        host_write(0, mk(1, 0, 0, 0, 100, 'h100));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset irq", int'(irq), 0);
        chk("reset buf_wr", int'(buf_wr), 0);
        chk("reset desc_wr", int'(desc_wr), 0);
        chk("reset rx_ready", int'(rx_ready), 1);

        // R8: short frame flushed into first buffer; R9 irq on end.
        exp_bytes('h100, 0, 20, 'h10);
        exp_wb(0, mk(0, 1, 1, 0, 20, 'h100));
        send_frame(20, 'h10, -1, 0, '0);
        drain();
        chk("R9 irq held high", int'(irq), 1);
        clear_irq();

        // R3/R7/R10: long frame over three owned buffers, early irq on.
        early_irq_en = 1;
        host_write(1, mk(1, 0, 0, 0, 64, 'h200));
        host_write(2, mk(1, 0, 0, 0, 64, 'h300));
        host_write(3, mk(1, 0, 0, 0, 100, 'h400));
        exp_bytes('h200, 0, 64, 'h40);
        exp_bytes('h300, 64, 64, 'h40);
        exp_bytes('h400, 128, 22, 'h40);
        exp_wb(1, mk(0, 1, 0, 0, 64, 'h200));
        exp_wb(2, mk(0, 0, 0, 0, 64, 'h300));
        exp_wb(3, mk(0, 0, 1, 0, 150, 'h400));
        send_frame(150, 'h40, -1, 0, '0);
        drain();
        clear_irq();

        // R4/R11: wrap to entry 0, next entry granted after the early read.
        early_irq_en = 0;
        host_write(0, mk(1, 0, 0, 0, 80, 'h500));
        exp_bytes('h500, 0, 80, 'h80);
        exp_bytes('h700, 80, 20, 'h80);
        exp_wb(0, mk(0, 1, 0, 0, 80, 'h500));
        exp_wb(1, mk(0, 0, 1, 0, 100, 'h700));
        send_frame(100, 'h80, 70, 1, mk(1, 0, 0, 0, 64, 'h700));
        drain();
        clear_irq();

        // R5: next entry never granted, buffer error and discard.
        host_write(2, mk(1, 0, 0, 0, 70, 'h600));
        wr_count = 0;
        exp_bytes('h600, 0, 70, 'hC0);
        exp_wb(2, mk(0, 1, 0, 1, 70, 'h600));
        send_frame(90, 'hC0, -1, 0, '0);
        drain();
        repeat (20) @(negedge clk);
        chk("R5 bytes written before error", wr_count, 70);
        clear_irq();

        // R1: entry 3 host-owned, nothing written until it is granted.
        wr_count = 0;
        send_frame(10, 'h33, -1, 0, '0);
        repeat (40) @(negedge clk);
        chk("R1 no writes while not owned", wr_count, 0);
        exp_bytes('h800, 0, 10, 'h33);
        exp_wb(3, mk(0, 1, 1, 0, 10, 'h800));
        host_write(3, mk(1, 0, 0, 0, 40, 'h800));
        drain();
        chk("R1 writes after grant", wr_count, 10);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule